// File: doc/BRIEF.md
# Two-Wire Switch-Bank Command Receiver

This block is a write-only slave on a two-wire serial bus that holds the enable bits of a four-channel switch bank. It watches the bus clock and data lines through a synchronizer running on a faster system clock, and it detects start and stop conditions. It then shifts in an address byte and answers only when that byte names this device. One address bit comes from a strap pin, so two copies of the block can share a bus.

After a matching write address, the block acknowledges and takes one command byte, which it also acknowledges. At the end of that second acknowledge, the low nibble of the command is copied to the four switch-enable outputs. The block never returns data to the master. Its only drive on the data line is the acknowledge, through an open-drain enable output.

Top module: `swb_i2c_slave`

## Requirements
- R1: The address byte arrives MSB first: seven address bits, then the R/W bit. It is acknowledged only if all of these hold: bits [6:3] equal ADDR_CODE (default 4'b1011), bit [2] equals addr_sel_i, bits [1:0] equal ADDR_LOW (default 2'b00), and R/W is 0.
- R2: An acknowledge holds sda_oe_o high for exactly one bus clock period. It is asserted on the SCL falling edge that ends the eighth bit and released on the next SCL falling edge.
- R3: After an acknowledged address, the following command byte receives a second acknowledge of the same form.
- R4: Command bit 0 drives sw_en_o[0] (switch 1), and so on up to bit 3, which drives sw_en_o[3] (switch 4). A 1 closes a switch and a 0 opens it. Command bits [7:4] are ignored.
- R5: sw_en_o changes only at the end of the second acknowledge. A stop inside the command byte leaves the outputs unchanged.
- R6: After a non-matching address or a read request, the block gives no acknowledge and does not drive SDA until the next start condition. The outputs stay unchanged.
- R7: sda_oe_o changes only while SCL is low and is never asserted during address or command data bits.
- R8: Reset clears all switch enables (every switch open) and releases SDA.
- R9: A repeated start at any point restarts address reception, so a complete write that follows it takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| addr_sel_i | input | 1 | Strap pin supplying address bit 2 |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain acknowledge) |
| sw_en_o | output | 4 | Switch enables, 1 = closed |

## Verification
Matching writes carry command bytes whose upper nibble is varied independently of the lower one. This shows that only bits [3:0] reach the switches and that they map in bit order. Addresses that differ from the device code only in the strapped bit, and addresses that match but carry a read request, separate a correct comparison from one that drops the pin or the R/W bit. Aborted frames, one cut short by a stop and one cut short by a repeated start inside the command byte, show whether the update is tied to the second acknowledge. Random frames then mix all of these cases with random pin levels.

// File: rtl/swb_pkg.sv
package swb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_CMD,
    ST_CMD_ACK,
    ST_SKIP
  } swb_state_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
    logic sda;
  } bus_ev_t;
endpackage

// File: rtl/swb_bus_sync.sv
module swb_bus_sync
  import swb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    scl_i,
  input  logic    sda_i,
  output bus_ev_t ev_o
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] scl_sh, sda_sh;
  logic         scl_d, sda_d;
  logic         scl_c, sda_c;

  // bus idles high, so reset to 1 to avoid a false start after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[MSB-1:0], scl_i};
      sda_sh <= {sda_sh[MSB-1:0], sda_i};
      scl_d  <= scl_sh[MSB];
      sda_d  <= sda_sh[MSB];
    end
  end

  assign scl_c = scl_sh[MSB];
  assign sda_c = sda_sh[MSB];

  always_comb begin
    ev_o.rise  = scl_c & ~scl_d;
    ev_o.fall  = ~scl_c & scl_d;
    ev_o.start = scl_c & scl_d & sda_d & ~sda_c;
    ev_o.stop  = scl_c & scl_d & ~sda_d & sda_c;
    ev_o.sda   = sda_c;
  end
endmodule

// File: rtl/swb_rx_fsm.sv
module swb_rx_fsm
  import swb_pkg::*;
#(
  parameter logic [3:0] ADDR_CODE = 4'b1011,
  parameter logic [1:0] ADDR_LOW  = 2'b00,
  parameter int         BYTE_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bus_ev_t           ev_i,
  input  logic              addr_sel_i,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] cmd_o,
  output logic              commit_o
);
  localparam int          CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

  swb_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic              oe_q;
  logic              addr_hit;

  // write request only: R/W bit must be 0
  assign addr_hit = (sh_q == {ADDR_CODE, addr_sel_i, ADDR_LOW, 1'b0});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      oe_q    <= 1'b0;
    end else if (ev_i.start) begin
      state_q <= ST_ADDR;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
    end else if (ev_i.stop) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_ADDR, ST_CMD: begin
          if (ev_i.rise && cnt_q != LAST) begin
            sh_q  <= {sh_q[BYTE_W-2:0], ev_i.sda};
            cnt_q <= cnt_q + 1'b1;
          end else if (ev_i.fall && cnt_q == LAST) begin
            cnt_q <= '0;
            if (state_q == ST_CMD) begin
              oe_q    <= 1'b1;
              state_q <= ST_CMD_ACK;
            end else if (addr_hit) begin
              oe_q    <= 1'b1;
              state_q <= ST_ADDR_ACK;
            end else begin
              state_q <= ST_SKIP;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (ev_i.fall) begin
            oe_q    <= 1'b0;
            state_q <= ST_CMD;
          end
        end
        ST_CMD_ACK: begin
          if (ev_i.fall) begin
            oe_q    <= 1'b0;
            state_q <= ST_SKIP;
          end
        end
        default: ;
      endcase
    end
  end

  assign commit_o = (state_q == ST_CMD_ACK) && ev_i.fall && !ev_i.start && !ev_i.stop;
  assign cmd_o    = sh_q;
  assign sda_oe_o = oe_q;
endmodule

// File: rtl/swb_sw_reg.sv
module swb_sw_reg #(
  parameter int SW_N = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            commit_i,
  input  logic [SW_N-1:0] cmd_i,
  output logic [SW_N-1:0] sw_en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sw_en_o <= '0;
    else if (commit_i) sw_en_o <= cmd_i;
  end
endmodule

// File: rtl/swb_i2c_slave.sv
module swb_i2c_slave
  import swb_pkg::*;
#(
  parameter logic [3:0] ADDR_CODE   = 4'b1011,
  parameter logic [1:0] ADDR_LOW    = 2'b00,
  parameter int         SYNC_STAGES = 2,
  parameter int         SW_N        = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            scl_i,
  input  logic            sda_i,
  input  logic            addr_sel_i,
  output logic            sda_oe_o,
  output logic [SW_N-1:0] sw_en_o
);
  localparam int BYTE_W = 8;

  bus_ev_t           ev;
  logic [BYTE_W-1:0] cmd;
  logic              commit;

  swb_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .scl_i  (scl_i),
    .sda_i  (sda_i),
    .ev_o   (ev)
  );

  swb_rx_fsm #(
    .ADDR_CODE (ADDR_CODE),
    .ADDR_LOW  (ADDR_LOW),
    .BYTE_W    (BYTE_W)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ev_i       (ev),
    .addr_sel_i (addr_sel_i),
    .sda_oe_o   (sda_oe_o),
    .cmd_o      (cmd),
    .commit_o   (commit)
  );

  // upper command bits are dropped here
  swb_sw_reg #(.SW_N(SW_N)) u_sw (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (commit),
    .cmd_i    (cmd[SW_N-1:0]),
    .sw_en_o  (sw_en_o)
  );
endmodule

// File: rtl/swb_i2c_slave_chk.sv
module swb_i2c_slave_chk #(
  parameter int SW_N = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            scl_i,
  input logic            sda_oe_o,
  input logic [SW_N-1:0] sw_en_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_CLEAR: assert (sw_en_o == '0 && !sda_oe_o); // R8
    end
  end

  AST_OE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i); // R7

  AST_SW_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sw_en_o) |-> !scl_i); // R5

  AST_SW_AT_ACK_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sw_en_o) |-> $fell(sda_oe_o)); // R5
endmodule

bind swb_i2c_slave swb_i2c_slave_chk #(.SW_N(SW_N)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_i    (scl_i),
  .sda_oe_o (sda_oe_o),
  .sw_en_o  (sw_en_o)
);

// File: tb/swb_i2c_slave_tb_top.sv
module swb_i2c_slave_tb_top;
  localparam int Q = 8;
  localparam logic [3:0] CODE = 4'b1011;
  localparam logic [1:0] LOW  = 2'b00;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       pin = 1'b0;
  logic       sda_oe;
  logic [3:0] sw;
  wire        sda_bus = sda_m & ~sda_oe;

  int  errors = 0;
  int  checks = 0;
  bit  done = 0;
  bit  oe_in_data;
  logic [3:0] exp_sw;

  always #5 clk = ~clk;

  swb_i2c_slave dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .scl_i      (scl),
    .sda_i      (sda_bus),
    .addr_sel_i (pin),
    .sda_oe_o   (sda_oe),
    .sw_en_o    (sw)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_ack(input logic [6:0] a, input logic rw, input logic p);
    return (a == {CODE, p, LOW}) && !rw;
  endfunction

  function automatic logic [3:0] exp_next(input logic [3:0] prev, input bit ack,
                                          input logic [7:0] cmd);
    return ack ? cmd[3:0] : prev;
  endfunction

  task automatic wq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wq(1);
    scl = 1'b1; wq(1);
    sda_m = 1'b0; wq(1);
    scl = 1'b0; wq(1);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wq(1);
    scl = 1'b1; wq(1);
    sda_m = 1'b1; wq(1);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wq(1);
    scl = 1'b1; wq(1);
    if (sda_oe) oe_in_data = 1'b1;
    wq(1);
    scl = 1'b0; wq(1);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; wq(1);
    scl = 1'b1; wq(1);
    ack = !sda_bus;
    wq(1);
    scl = 1'b0; wq(1);
  endtask

  task automatic write_txn(input logic [6:0] a, input logic rw, input logic [7:0] cmd,
                           input string tag);
    bit a1, a2, e;
    e = exp_ack(a, rw, pin);
    oe_in_data = 1'b0;
    bus_start();
    send_byte({a, rw}, a1);
    send_byte(cmd, a2);
    bus_stop();
    wq(1);
    exp_sw = exp_next(exp_sw, e, cmd);
    chk(a1 == e, e ? "R1" : "R6", {tag, " address ack"}, a1, e);
    chk(a2 == e, e ? "R3" : "R6", {tag, " command ack"}, a2, e);
    chk(sw == exp_sw, "R4", {tag, " switch outputs"}, sw, exp_sw);
    chk(!oe_in_data, "R7", {tag, " no drive in data bits"}, oe_in_data, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      chk(1'b0, "WDOG", "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit a1, a2;
    logic [6:0] ra;
    logic       rrw;
    void'($urandom(32'h5eed_1234));
    exp_sw = 4'h0;
    repeat (4) @(negedge clk);
    chk(sw == 4'h0 && !sda_oe, "R8", "reset state", {sda_oe, sw}, 0);
    rst_n = 1'b1;
    wq(2);

    // R2: acknowledge width and placement
    bus_start();
    for (int i = 7; i >= 0; i--) send_bit(bit'(({CODE, 1'b0, LOW, 1'b0} >> i) & 1));
    chk(sda_oe == 1'b1, "R2", "ack asserted after 8th bit fall", sda_oe, 1);
    sda_m = 1'b1; wq(1); scl = 1'b1; wq(2); scl = 1'b0;
    wq(1);
    chk(sda_oe == 1'b0, "R2", "ack released after ack clock", sda_oe, 0);
    for (int i = 7; i >= 0; i--) send_bit(bit'((8'h03 >> i) & 1));
    sda_m = 1'b1; wq(1); scl = 1'b1; wq(2); scl = 1'b0; wq(1);
    bus_stop(); wq(1);
    exp_sw = 4'h3;
    chk(sw == 4'h3, "R4", "first write 0x03", sw, 4'h3);

    write_txn({CODE, 1'b0, LOW}, 1'b0, 8'hA5, "R4 upper nibble ignored");
    write_txn({CODE, 1'b0, LOW}, 1'b0, 8'hF0, "R4 upper-only cmd");
    write_txn({CODE, 1'b0, LOW}, 1'b0, 8'h0E, "R4 bit order");
    write_txn({CODE, 1'b1, LOW}, 1'b0, 8'h01, "R1 strap mismatch");
    pin = 1'b1;
    write_txn({CODE, 1'b1, LOW}, 1'b0, 8'h09, "R1 strap high");
    write_txn({CODE, 1'b0, LOW}, 1'b0, 8'h06, "R1 strap high, bit2 low");
    write_txn({CODE, 1'b1, LOW}, 1'b1, 8'h0F, "R6 read request");
    write_txn({CODE, 1'b1, 2'b01}, 1'b0, 8'h0F, "R1 low bits mismatch");

    // R5: stop inside command byte
    bus_start();
    send_byte({CODE, 1'b1, LOW, 1'b0}, a1);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_stop(); wq(1);
    chk(sw == exp_sw, "R5", "stop mid-command keeps outputs", sw, exp_sw);

    // R9: repeated start inside command byte, then full write
    bus_start();
    send_byte({CODE, 1'b1, LOW, 1'b0}, a1);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    chk(sw == exp_sw, "R5", "partial command no update", sw, exp_sw);
    sda_m = 1'b1; wq(1); scl = 1'b1; wq(1); sda_m = 1'b0; wq(1); scl = 1'b0; wq(1);
    send_byte({CODE, 1'b1, LOW, 1'b0}, a1);
    send_byte(8'h0C, a2);
    bus_stop(); wq(1);
    exp_sw = 4'hC;
    chk(a1 && a2, "R9", "acks after repeated start", {a1, a2}, 3);
    chk(sw == 4'hC, "R9", "write after repeated start", sw, 4'hC);

    for (int n = 0; n < 40; n++) begin
      pin = 1'($urandom_range(0, 1));
      ra  = ($urandom_range(0, 1) != 0) ? {CODE, pin, LOW} : 7'($urandom);
      rrw = ($urandom_range(0, 3) == 0);
      write_txn(ra, rrw, 8'($urandom), "R1 random frame");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule